// File: doc/BRIEF.md
# Dual-Frame DMA Enable Sequencer

This block sequences the frame-buffer side of a display DMA channel. Software toggles the display on and off through a control write strobe. When the display turns on, the block checks that the start and end addresses of one frame-buffer region, or of both regions in dual-buffer mode, lie inside an allowed address window. If any required address falls outside, the start is aborted and an error condition is flagged. A valid start latches both region base addresses and, depending on the palette mode, requests a one-time palette fetch.

While the display runs, each frame-start strobe records a per-frame condition bit for the region being fetched. In dual-buffer mode the active region then alternates between the two. In single mode it stays on region 0. A sticky condition register holds these bits until a read-to-clear strobe. A level interrupt is high while any condition bit that is enabled is set. When the display turns off, the block parks in an idle state that is distinct from both frame indices, clears the sync-error flag and, unless the palette mode is palette-only, marks the frame as done.

Top module: `lcd_frame_seq`

## Requirements
- R1: After reset the display is off and the sequencer is idle. The frame index is 0, the condition bits are 000, and frame-done, palette-done, palette-load, sync-error and the interrupt are all 0.
- R2: A control write with enable 0 while the display is on turns it off, sets idle and the frame index to 0, and clears sync-error. It sets frame-done unless `pal_mode` is 1 (palette-only), in which case frame-done keeps its value.
- R3: A control write with enable 1 while the display is off and idle leaves idle, sets the frame index to 0, and clears frame-done and palette-done.
- R4: A start is valid when both frame-0 addresses lie in the inclusive window [WIN_LO, WIN_HI]; in dual mode both frame-1 addresses must lie there as well. An invalid start sets condition bit 2 and leaves the display off.
- R5: A valid start latches both top addresses. `frame_base` shows the latched top address of the region selected by `frame_idx`.
- R6: On a valid start with `pal_mode` not 2 and palette-done clear (after any clearing from R3), `pal_load` pulses high for one cycle and palette-done is set. With `pal_mode` 2 no load is requested.
- R7: A frame-start strobe while the display is on, with no control write in the same cycle, sets condition bit number `frame_idx` (bit 0 or bit 1). A frame-start strobe while the display is off has no effect.
- R8: After each accepted frame start, the frame index toggles in dual mode and stays 0 in single mode.
- R9: `dma_irq` is high exactly when (condition bit 0 or bit 1) is set with `dma_ie[0]`, or condition bit 2 is set with `dma_ie[1]`.
- R10: `cond_rd` clears all condition bits. A bit set in the same cycle wins over the clear.
- R11: A control write whose enable value equals the current display state changes nothing.
- R12: `sync_fault` sets sync-error. A disable clears it, and the clear wins if both happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_en | input | 1 | Enable value carried by the control write |
| pal_mode | input | 2 | Palette mode: 1 palette-only, 2 data-only |
| dual | input | 1 | Dual-buffer mode |
| f0_top | input | AW | Frame 0 start address |
| f0_bot | input | AW | Frame 0 end address |
| f1_top | input | AW | Frame 1 start address |
| f1_bot | input | AW | Frame 1 end address |
| dma_ie | input | 2 | Interrupt enables: bit 0 frame, bit 1 address error |
| frame_start | input | 1 | Frame start strobe |
| cond_rd | input | 1 | Read-to-clear strobe for condition bits |
| sync_fault | input | 1 | Sync error event |
| display_en | output | 1 | Display running |
| frame_idle | output | 1 | No frame selected |
| frame_idx | output | 1 | Current frame region |
| frame_base | output | AW | Base address of current region |
| cond | output | 3 | Condition bits: 0 frame0, 1 frame1, 2 address error |
| dma_irq | output | 1 | Level DMA interrupt |
| frame_done | output | 1 | Frame-done flag |
| palette_done | output | 1 | Palette-loaded flag |
| pal_load | output | 1 | One-cycle palette fetch request |
| sync_err | output | 1 | Sync-error flag |

## Verification
The enable that does not start from idle is the hardest case to reach. Every disable parks the sequencer in idle, so this case exists only after a start that was aborted. The stimulus first forces an abort by moving one frame-0 address out of the window. It then restores the address and enables again, and expects the palette to be fetched because the aborted start had already cleared palette-done. The dual-only check of frame 1 is reached the same way: a frame-1 address outside the window is accepted in single mode and rejected in dual mode.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
   localparam int NFRAME  = 2;
   localparam int NADDR   = 2 * NFRAME;
   localparam int NCOND   = NFRAME + 1;
   localparam int CB_ERR  = NFRAME;
   localparam logic [1:0] PM_PAL_ONLY  = 2'd1;
   localparam logic [1:0] PM_DATA_ONLY = 2'd2;
endpackage

// File: rtl/lcd_addr_window.sv
module lcd_addr_window #(
   parameter int AW = 16,
   parameter logic [AW-1:0] LO = '0,
   parameter logic [AW-1:0] HI = '1
) (
   input  logic [AW-1:0] addr,
   output logic          ok
);
   assign ok = (addr >= LO) && (addr <= HI);
endmodule

// File: rtl/lcd_cond_reg.sv
module lcd_cond_reg #(
   parameter int NB = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NB-1:0] set_vec,
   input  logic          clr_all,
   output logic [NB-1:0] bits
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bits <= '0;
      else        bits <= (clr_all ? '0 : bits) | set_vec;
   end
endmodule

// File: rtl/lcd_frame_ptr.sv
module lcd_frame_ptr #(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go_idle,
   input  logic          wake,
   input  logic          load_bases,
   input  logic [AW-1:0] top0,
   input  logic [AW-1:0] top1,
   input  logic          advance,
   input  logic          dual,
   output logic          idle,
   output logic          idx,
   output logic [AW-1:0] base
);
   logic [AW-1:0] base_q [2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle <= 1'b1;
         idx  <= 1'b0;
      end else if (go_idle) begin
         idle <= 1'b1;
         idx  <= 1'b0;
      end else if (wake) begin
         idle <= 1'b0;
         idx  <= 1'b0;
      end else if (advance && dual) begin
         idx  <= ~idx;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q[0] <= '0;
         base_q[1] <= '0;
      end else if (load_bases) begin
         base_q[0] <= top0;
         base_q[1] <= top1;
      end
   end

   assign base = base_q[idx];
endmodule

// File: rtl/lcd_frame_seq.sv
module lcd_frame_seq
   import lcd_seq_pkg::*;
#(
   parameter int AW = 16,
   parameter logic [AW-1:0] WIN_LO = 16'h1000,
   parameter logic [AW-1:0] WIN_HI = 16'h7FFF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctrl_wr,
   input  logic          ctrl_en,
   input  logic [1:0]    pal_mode,
   input  logic          dual,
   input  logic [AW-1:0] f0_top,
   input  logic [AW-1:0] f0_bot,
   input  logic [AW-1:0] f1_top,
   input  logic [AW-1:0] f1_bot,
   input  logic [1:0]    dma_ie,
   input  logic          frame_start,
   input  logic          cond_rd,
   input  logic          sync_fault,
   output logic          display_en,
   output logic          frame_idle,
   output logic          frame_idx,
   output logic [AW-1:0] frame_base,
   output logic [NCOND-1:0] cond,
   output logic          dma_irq,
   output logic          frame_done,
   output logic          palette_done,
   output logic          pal_load,
   output logic          sync_err
);
   generate
      if (AW < 2) begin : g_bad_aw
         $error("lcd_frame_seq: AW must be at least 2");
      end
      if (WIN_LO > WIN_HI) begin : g_bad_win
         $error("lcd_frame_seq: WIN_LO above WIN_HI");
      end
   endgenerate

   logic [AW-1:0]    addr_arr [NADDR];
   logic [NADDR-1:0] addr_ok;

   assign addr_arr[0] = f0_top;
   assign addr_arr[1] = f0_bot;
   assign addr_arr[2] = f1_top;
   assign addr_arr[3] = f1_bot;

   for (genvar i = 0; i < NADDR; i++) begin : g_win
      lcd_addr_window #(.AW(AW), .LO(WIN_LO), .HI(WIN_HI)) u_win (
         .addr (addr_arr[i]),
         .ok   (addr_ok[i])
      );
   end

   logic en_rise, en_fall, wake, valid, start_ok, start_bad;
   logic pd_eff, pal_req, advance;
   logic [NCOND-1:0] set_vec;

   assign en_rise   = ctrl_wr && ctrl_en && !display_en;
   assign en_fall   = ctrl_wr && !ctrl_en && display_en;
   assign wake      = en_rise && frame_idle;
   assign valid     = addr_ok[0] && addr_ok[1] && (!dual || (addr_ok[2] && addr_ok[3]));
   assign start_ok  = en_rise && valid;
   assign start_bad = en_rise && !valid;
   assign pd_eff    = frame_idle ? 1'b0 : palette_done;
   assign pal_req   = start_ok && (pal_mode != PM_DATA_ONLY) && !pd_eff;
   assign advance   = frame_start && display_en && !ctrl_wr;

   always_comb begin
      set_vec = '0;
      if (advance)   set_vec[frame_idx] = 1'b1;
      if (start_bad) set_vec[CB_ERR]    = 1'b1;
   end

   lcd_cond_reg #(.NB(NCOND)) u_cond (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (set_vec),
      .clr_all (cond_rd),
      .bits    (cond)
   );

   lcd_frame_ptr #(.AW(AW)) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .go_idle    (en_fall),
      .wake       (wake),
      .load_bases (start_ok),
      .top0       (f0_top),
      .top1       (f1_top),
      .advance    (advance),
      .dual       (dual),
      .idle       (frame_idle),
      .idx        (frame_idx),
      .base       (frame_base)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         display_en   <= 1'b0;
         frame_done   <= 1'b0;
         palette_done <= 1'b0;
         pal_load     <= 1'b0;
         sync_err     <= 1'b0;
      end else begin
         pal_load <= pal_req;
         if (en_fall)       display_en <= 1'b0;
         else if (start_ok) display_en <= 1'b1;
         if (en_fall && (pal_mode != PM_PAL_ONLY)) frame_done <= 1'b1;
         else if (wake)                           frame_done <= 1'b0;
         if (pal_req)   palette_done <= 1'b1;
         else if (wake) palette_done <= 1'b0;
         if (en_fall)         sync_err <= 1'b0;
         else if (sync_fault) sync_err <= 1'b1;
      end
   end

   assign dma_irq = ((cond[0] | cond[1]) & dma_ie[0]) | (cond[CB_ERR] & dma_ie[1]);
endmodule

// File: rtl/lcd_frame_seq_chk.sv
module lcd_frame_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       ctrl_wr,
   input logic       ctrl_en,
   input logic       dual,
   input logic       frame_start,
   input logic       cond_rd,
   input logic       display_en,
   input logic       frame_idle,
   input logic       frame_idx,
   input logic [2:0] cond,
   input logic       dma_irq,
   input logic       pal_load,
   input logic       sync_err
);
   AST_DISABLE_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !ctrl_en && display_en) |=> (frame_idle && !display_en && !sync_err)); // R2
   AST_PAL_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      pal_load |=> !pal_load); // R6
   AST_FRAME0_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && display_en && !ctrl_wr && !frame_idx) |=> cond[0]); // R7
   AST_OFF_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && !display_en && !ctrl_wr && !cond_rd) |=> (cond == $past(cond))); // R7
   AST_DUAL_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && display_en && !ctrl_wr && dual) |=> (frame_idx != $past(frame_idx))); // R8
   AST_SINGLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && display_en && !ctrl_wr && !dual && !frame_idx) |=> !frame_idx); // R8
   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cond == 3'b000) |-> !dma_irq); // R9
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_rd && !frame_start && !ctrl_wr) |=> (cond == 3'b000)); // R10
endmodule

bind lcd_frame_seq lcd_frame_seq_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ctrl_wr     (ctrl_wr),
   .ctrl_en     (ctrl_en),
   .dual        (dual),
   .frame_start (frame_start),
   .cond_rd     (cond_rd),
   .display_en  (display_en),
   .frame_idle  (frame_idle),
   .frame_idx   (frame_idx),
   .cond        (cond),
   .dma_irq     (dma_irq),
   .pal_load    (pal_load),
   .sync_err    (sync_err)
);

// File: tb/lcd_frame_seq_test.sv
module lcd_frame_seq_test;
   localparam int CLK_P = 10;
   localparam int AW = 16;
   localparam logic [AW-1:0] T0 = 16'h1000, B0 = 16'h2000, T1 = 16'h3000, B1 = 16'h7FFF;

   typedef struct packed {
      logic wr, en, dl; logic [1:0] pm; logic fs, rd;
      logic de, idle, idx; logic [2:0] cn; logic fd, pd, pl;
   } vec_t;

   // wr en dl pm fs rd | de idle idx cond fd pd pl
   localparam vec_t TBL [12] = '{
      '{1,1,1,2'd0,0,0, 1,0,0,3'b000,0,1,1}, // R3 R5 R6 valid dual start, palette fetch
      '{0,0,1,2'd0,1,0, 1,0,1,3'b001,0,1,0}, // R7 R8 frame 0 marked, toggle
      '{0,0,1,2'd0,1,0, 1,0,0,3'b011,0,1,0}, // R7 R8 frame 1 marked, toggle back
      '{0,0,1,2'd0,0,1, 1,0,0,3'b000,0,1,0}, // R10 read clears
      '{0,0,1,2'd0,1,1, 1,0,1,3'b001,0,1,0}, // R10 set wins over clear
      '{1,1,1,2'd0,0,0, 1,0,1,3'b001,0,1,0}, // R11 same enable, no change
      '{1,0,1,2'd0,0,0, 0,1,0,3'b001,1,1,0}, // R2 disable sets frame-done
      '{0,0,1,2'd0,1,0, 0,1,0,3'b001,1,1,0}, // R7 frame start ignored while off
      '{1,1,0,2'd2,0,1, 1,0,0,3'b000,0,0,0}, // R3 R6 data-only start: no palette
      '{0,0,0,2'd2,1,0, 1,0,0,3'b001,0,0,0}, // R8 single mode stays 0
      '{0,0,0,2'd2,1,0, 1,0,0,3'b001,0,0,0}, // R8 single mode again
      '{1,0,0,2'd1,0,0, 0,1,0,3'b001,0,0,0}  // R2 palette-only disable keeps frame-done
   };

   logic clk = 0, rst_n = 0;
   logic ctrl_wr = 0, ctrl_en = 0, dual = 0, frame_start = 0, cond_rd = 0, sync_fault = 0;
   logic [1:0] pal_mode = 0, dma_ie = 2'b01;
   logic [AW-1:0] f0_top = T0, f0_bot = B0, f1_top = T1, f1_bot = B1;
   logic display_en, frame_idle, frame_idx, dma_irq, frame_done, palette_done, pal_load, sync_err;
   logic [AW-1:0] frame_base;
   logic [2:0] cond;
   int errors = 0, checks = 0;
   bit finished = 0;

   always #(CLK_P/2) clk = ~clk;

   lcd_frame_seq #(.AW(AW), .WIN_LO(16'h1000), .WIN_HI(16'h7FFF)) uut (
      .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_en(ctrl_en), .pal_mode(pal_mode),
      .dual(dual), .f0_top(f0_top), .f0_bot(f0_bot), .f1_top(f1_top), .f1_bot(f1_bot),
      .dma_ie(dma_ie), .frame_start(frame_start), .cond_rd(cond_rd), .sync_fault(sync_fault),
      .display_en(display_en), .frame_idle(frame_idle), .frame_idx(frame_idx),
      .frame_base(frame_base), .cond(cond), .dma_irq(dma_irq), .frame_done(frame_done),
      .palette_done(palette_done), .pal_load(pal_load), .sync_err(sync_err));

   task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", what, got, exp);
      end
   endtask

   // drive at a negedge, let one posedge pass, return at the next negedge with strobes cleared
   task automatic step(input logic wr, en, fs, rd, sf);
      ctrl_wr = wr; ctrl_en = en; frame_start = fs; cond_rd = rd; sync_fault = sf;
      @(negedge clk);
      ctrl_wr = 0; frame_start = 0; cond_rd = 0; sync_fault = 0;
   endtask

   function automatic logic [9:0] obs();
      return {display_en, frame_idle, frame_idx, cond, frame_done, palette_done, pal_load, sync_err};
   endfunction

   initial begin
      #(CLK_P * 100000);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 reset state", {22'd0, obs()}, {22'd0, 10'b0100000000});
      chk("R1 reset irq", {31'd0, dma_irq}, 0);

      foreach (TBL[i]) begin
         dual = TBL[i].dl; pal_mode = TBL[i].pm;
         step(TBL[i].wr, TBL[i].en, TBL[i].fs, TBL[i].rd, 0);
         chk($sformatf("R2/R3/R6/R7/R8/R10/R11 vector %0d", i),
             {23'd0, display_en, frame_idle, frame_idx, cond, frame_done, palette_done, pal_load},
             {23'd0, TBL[i].de, TBL[i].idle, TBL[i].idx, TBL[i].cn, TBL[i].fd, TBL[i].pd, TBL[i].pl});
         chk($sformatf("R9 irq vector %0d", i), {31'd0, dma_irq}, {31'd0, TBL[i].cn[0] | TBL[i].cn[1]});
         chk($sformatf("R5 base vector %0d", i), {16'd0, frame_base},
             {16'd0, TBL[i].idx ? T1 : T0});
      end

      // R4 abort: frame-0 end outside the window
      step(0, 0, 0, 1, 0);
      f0_bot = 16'h8000; dual = 0; pal_mode = 0; dma_ie = 2'b10;
      step(1, 1, 0, 0, 0);
      chk("R4 abort keeps display off", {31'd0, display_en}, 0);
      chk("R4 abort sets cond bit 2", {29'd0, cond}, 3'b100);
      chk("R3 abort from idle leaves idle", {31'd0, frame_idle}, 0);
      chk("R9 error irq enabled", {31'd0, dma_irq}, 1);
      dma_ie = 2'b01;
      @(negedge clk);
      chk("R9 error irq masked", {31'd0, dma_irq}, 0);

      // R4 single mode ignores frame 1; enable not from idle still fetches palette
      f0_bot = B0; f1_top = 16'h0800;
      step(0, 0, 0, 1, 0);
      step(1, 1, 0, 0, 0);
      chk("R4 single start ignores frame 1", {31'd0, display_en}, 1);
      chk("R6 palette fetched after abort", {30'd0, pal_load, palette_done}, 2'b11);
      chk("R5 base after restart", {16'd0, frame_base}, {16'd0, T0});

      // R4 dual mode rejects bad frame-1 address
      step(1, 0, 0, 0, 0);
      dual = 1;
      step(1, 1, 0, 0, 0);
      chk("R4 dual start rejected", {28'd0, display_en, cond}, {28'd0, 1'b0, 3'b100});

      // R12 sync error set and cleared by disable
      f1_top = T1;
      step(0, 0, 0, 0, 1);
      chk("R12 sync fault sets flag", {31'd0, sync_err}, 1);
      step(1, 1, 0, 0, 0);
      chk("R12 flag held while running", {30'd0, display_en, sync_err}, 2'b11);
      step(1, 0, 0, 0, 1);
      chk("R12 disable clear wins", {30'd0, display_en, sync_err}, 2'b00);

      // R9 all enables off
      dma_ie = 2'b00;
      @(negedge clk);
      chk("R9 irq with enables off", {31'd0, dma_irq}, 0);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule